// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every cycle, which hardware thread contexts of a simultaneously multithreaded front end may fetch instructions and how many each may take. It splits the fetch bandwidth between up to two threads, favouring the threads that currently hold the fewest instructions in the decode and instruction-queue stages. Picking those threads keeps a single slow thread from filling the shared queue.

The per-thread in-flight counts come from outside the block. An idle, stalled or parked thread never competes. When the shared instruction queue has reached its capacity, no thread is picked. Threads that hold equal counts are ordered by a rotating pointer, so that equal threads take turns. In non-speculative operation a thread that has just fetched a branch is parked until that branch is reported resolved. The outputs are combinational from the inputs and from the pointer and parking state.

Top module: `fetch_thread_pick`

## Requirements
- R1: At most two threads are picked per cycle. Slot 1 is valid only when slot 0 is valid, and its thread id differs from slot 0's.
- R2: A thread can be picked only when its `thr_active` bit is 1, its `thr_stall` bit is 0 and it is not parked.
- R3: Thread t's count is `front_cnt[6*t+5:6*t]`, an unsigned 6-bit value. Slot 0 takes the eligible thread with the lowest count, and slot 1 takes the lowest among the rest.
- R4: Among equal counts, the thread whose distance (t - ptr) mod 8 is smallest wins. The pointer is 0 after reset. After any cycle with slot 0 valid it becomes (slot 0 id + 1) mod 8, and otherwise it holds its value.
- R5: With two threads picked, each slot's count is 4. With one thread picked, slot 0's count is 8, and slot 1 is invalid with id 0 and count 0.
- R6: With no eligible thread, both slots are invalid, with ids 0 and counts 0.
- R7: When `iq_level` is 32 or more, no thread is picked and the pointer holds its value.
- R8: While `nonspec_mode` is 1, `br_fetched[t]` at a clock edge parks thread t from the next cycle on. A `br_resolved[t]` seen at a later edge releases it from the cycle after that edge. While `nonspec_mode` is 0, `br_fetched` has no effect.
- R9: While reset is asserted, the pointer is 0 and no thread is parked, and the outputs still reflect the eligibility inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | 8 | Thread context holds a running program |
| thr_stall | input | 8 | Thread blocked this cycle (cache miss or flush) |
| front_cnt | input | 48 | Packed 6-bit in-flight counts, thread t at bits 6t+5..6t |
| iq_level | input | 6 | Current instruction-queue occupancy |
| nonspec_mode | input | 1 | 1 = park threads after a fetched branch |
| br_fetched | input | 8 | Thread fetched a branch this cycle |
| br_resolved | input | 8 | Thread's outstanding branch resolved this cycle |
| sel0_vld | output | 1 | Slot 0 holds a thread |
| sel0_tid | output | 3 | Slot 0 thread id |
| sel0_cnt | output | 4 | Slot 0 fetch count |
| sel1_vld | output | 1 | Slot 1 holds a thread |
| sel1_tid | output | 3 | Slot 1 thread id |
| sel1_cnt | output | 4 | Slot 1 fetch count |

## Verification
The bench builds the block with its defaults: 8 threads, 6-bit counts, a bandwidth of 8 and a queue capacity of 32. With these values the pointer wrap from thread 7 back to thread 0 can be reached, as can the full-scale count of 63 against 62 and the exact queue threshold of 32 against 31. A short parking sequence follows one thread through its branch, its hold cycles, the cycle in which it is resolved and its release, and then repeats the branch in speculative mode.

// File: rtl/fetch_thread_pick.sv
module fetch_thread_pick #(
  parameter int NTHR    = 8,
  parameter int CW      = 6,
  parameter int FETCH_W = 8,
  parameter int QDEPTH  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NTHR-1:0]          thr_active,
  input  logic [NTHR-1:0]          thr_stall,
  input  logic [NTHR*CW-1:0]       front_cnt,
  input  logic [$clog2(QDEPTH+1)-1:0] iq_level,
  input  logic                     nonspec_mode,
  input  logic [NTHR-1:0]          br_fetched,
  input  logic [NTHR-1:0]          br_resolved,
  output logic                     sel0_vld,
  output logic [$clog2(NTHR)-1:0]  sel0_tid,
  output logic [$clog2(FETCH_W+1)-1:0] sel0_cnt,
  output logic                     sel1_vld,
  output logic [$clog2(NTHR)-1:0]  sel1_tid,
  output logic [$clog2(FETCH_W+1)-1:0] sel1_cnt
);
  localparam int TW = $clog2(NTHR);
  localparam int FW = $clog2(FETCH_W+1);
  localparam int LW = $clog2(QDEPTH+1);
  localparam logic [LW-1:0] QCAP = LW'(QDEPTH);
  localparam logic [FW-1:0] FULL = FW'(FETCH_W);
  localparam logic [FW-1:0] HALF = FW'(FETCH_W/2);
  localparam logic [TW-1:0] LAST = TW'(NTHR-1);

  logic [TW-1:0]   ptr_q;
  logic [NTHR-1:0] parked_q;
  logic [NTHR-1:0] elig;
  logic            room;
  logic            f0, f1;
  logic [TW-1:0]   b0, b1;

  assign room = iq_level < QCAP;
  assign elig = thr_active & ~thr_stall & ~parked_q & {NTHR{room}};

  always_comb begin
    logic [CW-1:0] c, c0, c1;
    logic [TW-1:0] d, d0, d1;
    f0 = 1'b0; b0 = '0; c0 = '0; d0 = '0;
    f1 = 1'b0; b1 = '0; c1 = '0; d1 = '0;
    for (int t = 0; t < NTHR; t++) begin
      c = front_cnt[t*CW +: CW];
      d = TW'((t + NTHR - int'(ptr_q)) % NTHR);
      if (elig[t] && (!f0 || c < c0 || (c == c0 && d < d0))) begin
        f0 = 1'b1; b0 = TW'(t); c0 = c; d0 = d;
      end
    end
    for (int t = 0; t < NTHR; t++) begin
      c = front_cnt[t*CW +: CW];
      d = TW'((t + NTHR - int'(ptr_q)) % NTHR);
      if (elig[t] && f0 && TW'(t) != b0 && (!f1 || c < c1 || (c == c1 && d < d1))) begin
        f1 = 1'b1; b1 = TW'(t); c1 = c; d1 = d;
      end
    end
  end

  assign sel0_vld = f0;
  assign sel0_tid = f0 ? b0 : '0;
  assign sel0_cnt = f0 ? (f1 ? HALF : FULL) : '0;
  assign sel1_vld = f1;
  assign sel1_tid = f1 ? b1 : '0;
  assign sel1_cnt = f1 ? HALF : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (f0) ptr_q <= (b0 == LAST) ? '0 : b0 + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) parked_q <= '0;
    else parked_q <= (parked_q & ~br_resolved) | (br_fetched & {NTHR{nonspec_mode}});
  end

  a_r1_two_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    sel1_vld |-> sel0_vld && sel0_tid != sel1_tid);

  a_r2_eligible_only: assert property (@(posedge clk) disable iff (!rst_n)
    sel0_vld |-> thr_active[sel0_tid] && !thr_stall[sel0_tid]);

  a_r3_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    sel1_vld |-> front_cnt[int'(sel0_tid)*CW +: CW] <= front_cnt[int'(sel1_tid)*CW +: CW]);

  a_r5_bandwidth: assert property (@(posedge clk) disable iff (!rst_n)
    sel0_vld |-> int'(sel0_cnt) + int'(sel1_cnt) == FETCH_W);

  a_r6_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(thr_active & ~thr_stall)) |-> !sel0_vld && !sel1_vld);

  a_r7_queue_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_level >= QCAP) |-> !sel0_vld);

  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel0_vld |=> $stable(ptr_q));

  for (genvar g = 0; g < NTHR; g++) begin : g_park
    a_r8_parked: assert property (@(posedge clk) disable iff (!rst_n)
      nonspec_mode && br_fetched[g] |=>
        !(sel0_vld && sel0_tid == TW'(g)) && !(sel1_vld && sel1_tid == TW'(g)));
  end
endmodule

// File: tb/fetch_thread_pick_bench.sv
module fetch_thread_pick_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] act = '0, stl = '0, brf = '0, brr = '0;
  logic [5:0] cnt [8];
  logic [47:0] front_cnt;
  logic [5:0] iq = '0;
  logic nspec = 1'b0;
  logic s0v, s1v;
  logic [2:0] s0t, s1t;
  logic [3:0] s0c, s1c;
  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    string tag;
    bit v0; int t0; int c0;
    bit v1; int t1; int c1;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) front_cnt[i*6 +: 6] = cnt[i];

  fetch_thread_pick u_fetch_thread_pick (
    .clk(clk), .rst_n(rst_n), .thr_active(act), .thr_stall(stl),
    .front_cnt(front_cnt), .iq_level(iq), .nonspec_mode(nspec),
    .br_fetched(brf), .br_resolved(brr),
    .sel0_vld(s0v), .sel0_tid(s0t), .sel0_cnt(s0c),
    .sel1_vld(s1v), .sel1_tid(s1t), .sel1_cnt(s1c));

  task automatic expect_sel(input string tag, input bit v0, input int t0, input int c0,
                            input bit v1, input int t1, input int c1);
    exp_t e;
    e.tag = tag; e.v0 = v0; e.t0 = t0; e.c0 = c0; e.v1 = v1; e.t1 = t1; e.c1 = c1;
    q.push_back(e);
  endtask

  task automatic all_cnt(input int v);
    for (int i = 0; i < 8; i++) cnt[i] = 6'(v);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #4;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (s0v !== e.v0 || int'(s0t) != e.t0 || int'(s0c) != e.c0 ||
            s1v !== e.v1 || int'(s1t) != e.t1 || int'(s1c) != e.c1) begin
          failures++;
          $display("FAIL %s: got v0=%b t0=%0d c0=%0d v1=%b t1=%0d c1=%0d exp v0=%b t0=%0d c0=%0d v1=%b t1=%0d c1=%0d",
                   e.tag, s0v, s0t, s0c, s1v, s1t, s1c, e.v0, e.t0, e.c0, e.v1, e.t1, e.c1);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    all_cnt(0);
    // R9 reset: pointer 0
    @(negedge clk); act = 8'hFF; expect_sel("R9 reset pick", 1, 0, 4, 1, 1, 4);
    @(negedge clk); expect_sel("R9 reset holds ptr", 1, 0, 4, 1, 1, 4);
    @(negedge clk); rst_n = 1'b1; act = 8'h00; expect_sel("R6 none eligible", 0, 0, 0, 0, 0, 0);
    // R3 lowest counts
    @(negedge clk); act = 8'hFF;
    cnt[0] = 10; cnt[1] = 5; cnt[2] = 7; cnt[3] = 3; cnt[4] = 20; cnt[5] = 9; cnt[6] = 30; cnt[7] = 12;
    expect_sel("R3 two lowest", 1, 3, 4, 1, 1, 4);
    // R4 ties rotate (ptr 4 then 5)
    @(negedge clk); all_cnt(2); expect_sel("R4 tie from ptr4", 1, 4, 4, 1, 5, 4);
    @(negedge clk); expect_sel("R4 tie rotates", 1, 5, 4, 1, 6, 4);
    @(negedge clk); act = 8'b1000_0010; all_cnt(1); expect_sel("R4 wrap distance", 1, 7, 4, 1, 1, 4);
    // R5 single thread gets full bandwidth (ptr 0)
    @(negedge clk); act = 8'b0000_0100; expect_sel("R5 single full", 1, 2, 8, 0, 0, 0);
    // R2 stalls exclude (ptr 3)
    @(negedge clk); act = 8'hFF; stl = 8'b1011_1110; all_cnt(0); cnt[0] = 8; cnt[6] = 4;
    expect_sel("R2 stalled excluded", 1, 6, 4, 1, 0, 4);
    // R7 queue full (ptr 7)
    @(negedge clk); stl = '0; all_cnt(0); iq = 6'd32; expect_sel("R7 queue full", 0, 0, 0, 0, 0, 0);
    @(negedge clk); iq = 6'd31; expect_sel("R7 ptr held below cap", 1, 7, 4, 1, 0, 4);
    // R8 nonspec parking (ptr 0)
    @(negedge clk); iq = '0; nspec = 1'b1; all_cnt(5); cnt[3] = 0; brf = 8'b0000_1000;
    expect_sel("R8 branch cycle", 1, 3, 4, 1, 0, 4);
    @(negedge clk); brf = '0; expect_sel("R8 parked", 1, 4, 4, 1, 5, 4);
    @(negedge clk); brr = 8'b0000_1000; expect_sel("R8 parked in resolve cycle", 1, 5, 4, 1, 6, 4);
    @(negedge clk); brr = '0; expect_sel("R8 released", 1, 3, 4, 1, 6, 4);
    // R8 speculative mode ignores branches (ptr 4)
    @(negedge clk); nspec = 1'b0; brf = 8'b0000_1000; expect_sel("R8 spec branch cycle", 1, 3, 4, 1, 4, 4);
    @(negedge clk); brf = '0; expect_sel("R8 spec not parked", 1, 3, 4, 1, 4, 4);
    // R3 count boundary (ptr 4)
    @(negedge clk); act = 8'b0010_0001; cnt[0] = 63; cnt[5] = 62;
    expect_sel("R3 63 vs 62", 1, 5, 4, 1, 0, 4);
    // R1/R5 one eligible among many (ptr 6)
    @(negedge clk); act = 8'hFF; stl = 8'b0111_1111; expect_sel("R1 R5 lone thread", 1, 7, 8, 0, 0, 0);
    @(negedge clk); stl = '0; act = '0; expect_sel("R6 idle again", 0, 0, 0, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule